// File: doc/BRIEF.md
# Either-Edge GPIO Interrupt Controller

This block watches a small group of general-purpose input pins and turns their level changes into latched interrupt status. Each pin carries its own mode select. With the select set, a change in either direction on the pin latches that pin's wake (PME) and system-management (SMI) status bits. With the select clear, only the one edge chosen by the pin's polarity bit latches them. A separate aggregate register gathers an edge flag for every pin, so software can find all the pins that moved with a single read.

Software reaches the block through a small synchronous register port. Configuration registers (mode select, the two enables and polarity) are read/write. The three status views are cleared by writing one to a bit. A data register returns each pin's synchronized level, inverted where the polarity bit is set. The PME and SMI outputs are active-high levels. A pin drives them only while it is in either-edge mode, its status bit is set and its enable bit is set, and they stay high until software clears the status.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register at addresses 0 to 6 reads zero and both `pme_o` and `smi_o` are low.
- R2: Register map (3-bit address, bit i belongs to pin i): 0 either-edge mode select, 1 PME enable, 2 SMI enable, 3 PME status, 4 SMI status, 5 aggregate status, 6 polarity, 7 pin data (read-only). Addresses 0, 1, 2 and 6 read back the value last written.
- R3: With the mode bit set, both a rising and a falling transition on a pin set that pin's PME and SMI status bits. The status is readable from the third rising clock edge after the pin changes.
- R4: With the mode bit clear, a pin's PME and SMI status bits are set only by a rising transition when its polarity bit is 0, or only by a falling transition when its polarity bit is 1.
- R5: In either-edge mode the polarity bit does not change which transitions set status: both directions set it for either polarity value.
- R6: An aggregate status bit (address 5) is set by any transition on its pin, whatever the mode bit holds.
- R7: Writing a one to a bit of address 3, 4 or 5 clears that bit. Writing a zero leaves the bit unchanged.
- R8: If a pin edge and a clearing write to the same status bit act on the same clock edge, the bit remains one.
- R9: Status bits latch edges while the enables are clear. `pme_o` (`smi_o`) is high exactly when some pin has its mode bit, PME (SMI) enable bit and PME (SMI) status bit all set. It stays high until that status is cleared.
- R10: Address 7 returns, for each pin, the synchronized pin level XOR the pin's polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NPINS | Asynchronous GPIO input levels |
| addr | input | AW | Register address |
| wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Combinational read data for `addr` |
| pme_o | output | 1 | Wake interrupt request, active high |
| smi_o | output | 1 | System-management interrupt request, active high |

## Verification
An edge arriving on a pin and a software write-one-to-clear of that same status bit can act on the same clock edge. The bench provokes this by changing a pin level and then timing the clearing write to the PME status register so that it is in force on the third rising edge after the change, which is the edge where the synchronized edge pulse latches. The bench judges the outcome by reading the bit back as one, and then confirms that an ordinary clearing write afterwards does clear it.

// File: rtl/gei_pkg.sv
package gei_pkg;
   // Register addresses; the low three address bits select a register.
   localparam int REG_MODE   = 0;
   localparam int REG_PME_EN = 1;
   localparam int REG_SMI_EN = 2;
   localparam int REG_PME_ST = 3;
   localparam int REG_SMI_ST = 4;
   localparam int REG_AGG_ST = 5;
   localparam int REG_POL    = 6;
   localparam int REG_DATA   = 7;
   localparam int REG_COUNT  = 8;
   localparam int MIN_AW     = $clog2(REG_COUNT);

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;
endpackage

// File: rtl/gei_edge_det.sv
module gei_edge_det #(
   parameter int NPINS       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] level,
   output logic [NPINS-1:0] rise,
   output logic [NPINS-1:0] fall
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [NPINS-1:0] stage_q [SYNC_STAGES];
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= pin_in;
         for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
         prev_q <= stage_q[LAST];
      end
   end

   genvar p;
   generate
      for (p = 0; p < NPINS; p++) begin : g_pin
         gei_pkg::edge_t e;
         always_comb begin
            e.rise = stage_q[LAST][p] & ~prev_q[p];
            e.fall = ~stage_q[LAST][p] & prev_q[p];
         end
         assign rise[p] = e.rise;
         assign fall[p] = e.fall;
      end
   endgenerate

   assign level = stage_q[LAST];
endmodule

// File: rtl/gei_w1c_bank.sv
module gei_w1c_bank #(
   parameter int NPINS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] set_i,
   input  logic [NPINS-1:0] clr_i,
   output logic [NPINS-1:0] sts_o
);
   logic [NPINS-1:0] sts_q;

   // Set has priority over clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_i) | set_i;
   end

   assign sts_o = sts_q;
endmodule

// File: rtl/gei_cfg_regs.sv
module gei_cfg_regs #(
   parameter int NPINS = 6,
   parameter int AW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             wr_en,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] pme_sts,
   input  logic [NPINS-1:0] smi_sts,
   input  logic [NPINS-1:0] agg_sts,
   input  logic [NPINS-1:0] level,
   output logic [NPINS-1:0] mode_q,
   output logic [NPINS-1:0] pme_en_q,
   output logic [NPINS-1:0] smi_en_q,
   output logic [NPINS-1:0] pol_q,
   output logic [NPINS-1:0] pme_clr,
   output logic [NPINS-1:0] smi_clr,
   output logic [NPINS-1:0] agg_clr,
   output logic [NPINS-1:0] rdata
);
   import gei_pkg::*;

   logic [REG_COUNT-1:0] hit;

   always_comb begin
      for (int r = 0; r < REG_COUNT; r++) hit[r] = (addr == AW'(r));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         pme_en_q <= '0;
         smi_en_q <= '0;
         pol_q    <= '0;
      end else if (wr_en) begin
         if (hit[REG_MODE])   mode_q   <= wdata;
         if (hit[REG_PME_EN]) pme_en_q <= wdata;
         if (hit[REG_SMI_EN]) smi_en_q <= wdata;
         if (hit[REG_POL])    pol_q    <= wdata;
      end
   end

   assign pme_clr = (wr_en && hit[REG_PME_ST]) ? wdata : '0;
   assign smi_clr = (wr_en && hit[REG_SMI_ST]) ? wdata : '0;
   assign agg_clr = (wr_en && hit[REG_AGG_ST]) ? wdata : '0;

   always_comb begin
      rdata = '0;
      unique case (1'b1)
         hit[REG_MODE]:   rdata = mode_q;
         hit[REG_PME_EN]: rdata = pme_en_q;
         hit[REG_SMI_EN]: rdata = smi_en_q;
         hit[REG_PME_ST]: rdata = pme_sts;
         hit[REG_SMI_ST]: rdata = smi_sts;
         hit[REG_AGG_ST]: rdata = agg_sts;
         hit[REG_POL]:    rdata = pol_q;
         hit[REG_DATA]:   rdata = level ^ pol_q;
         default:         rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int NPINS       = 6,
   parameter int AW          = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [AW-1:0]    addr,
   input  logic             wr_en,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] rdata,
   output logic             pme_o,
   output logic             smi_o
);
   import gei_pkg::*;

   generate
      if (NPINS < 1)       begin : g_bad_npins $error("NPINS must be at least 1"); end
      if (AW < MIN_AW)     begin : g_bad_aw    $error("AW too narrow for the register map"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic [NPINS-1:0] level, rise, fall, any_edge;
   logic [NPINS-1:0] mode_q, pme_en_q, smi_en_q, pol_q;
   logic [NPINS-1:0] pme_clr, smi_clr, agg_clr;
   logic [NPINS-1:0] pme_sts, smi_sts, agg_sts;
   logic [NPINS-1:0] irq_set;
   logic             pme_raw, smi_raw;

   gei_edge_det #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .level(level), .rise(rise), .fall(fall)
   );

   assign any_edge = rise | fall;
   // Either-edge mode: both directions; otherwise polarity picks one direction.
   assign irq_set  = (mode_q & any_edge)
                   | (~mode_q & ~pol_q & rise)
                   | (~mode_q &  pol_q & fall);

   gei_cfg_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .pme_sts(pme_sts), .smi_sts(smi_sts), .agg_sts(agg_sts), .level(level),
      .mode_q(mode_q), .pme_en_q(pme_en_q), .smi_en_q(smi_en_q), .pol_q(pol_q),
      .pme_clr(pme_clr), .smi_clr(smi_clr), .agg_clr(agg_clr), .rdata(rdata)
   );

   gei_w1c_bank #(.NPINS(NPINS)) u_pme (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(pme_clr), .sts_o(pme_sts)
   );
   gei_w1c_bank #(.NPINS(NPINS)) u_smi (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(smi_clr), .sts_o(smi_sts)
   );
   gei_w1c_bank #(.NPINS(NPINS)) u_agg (
      .clk(clk), .rst_n(rst_n), .set_i(any_edge), .clr_i(agg_clr), .sts_o(agg_sts)
   );

   assign pme_raw = |(pme_sts & pme_en_q & mode_q);
   assign smi_raw = |(smi_sts & smi_en_q & mode_q);

   generate
      if (REG_OUT) begin : g_out_reg
         logic pme_q, smi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pme_q <= 1'b0;
               smi_q <= 1'b0;
            end else begin
               pme_q <= pme_raw;
               smi_q <= smi_raw;
            end
         end
         assign pme_o = pme_q;
         assign smi_o = smi_q;
      end else begin : g_out_comb
         assign pme_o = pme_raw;
         assign smi_o = smi_raw;
      end
   endgenerate
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
   parameter int NPINS   = 6,
   parameter int AW      = 3,
   parameter bit REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    addr,
   input logic             wr_en,
   input logic [NPINS-1:0] wdata,
   input logic [NPINS-1:0] mode_q,
   input logic [NPINS-1:0] any_edge,
   input logic [NPINS-1:0] irq_set,
   input logic [NPINS-1:0] pme_sts,
   input logic [NPINS-1:0] smi_sts,
   input logic [NPINS-1:0] agg_sts,
   input logic             pme_o,
   input logic             smi_o
);
   import gei_pkg::*;

   logic wr_pme, wr_smi, wr_agg;
   assign wr_pme = wr_en && (addr == AW'(REG_PME_ST));
   assign wr_smi = wr_en && (addr == AW'(REG_SMI_ST));
   assign wr_agg = wr_en && (addr == AW'(REG_AGG_ST));

   // R3: an edge on a pin in either-edge mode lands in both status views.
   assert_both_edges_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pme_sts & smi_sts) & $past(mode_q & any_edge)) == $past(mode_q & any_edge)));

   // R6: any edge lands in the aggregate view regardless of mode.
   assert_agg_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((agg_sts & $past(any_edge)) == $past(any_edge)));

   // R7: clearing write drops the bits it names unless an edge sets them.
   assert_pme_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pme |=> ((pme_sts & $past(wdata) & ~$past(irq_set)) == '0));

   // R7: without a clearing write no status bit falls.
   assert_pme_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pme |=> ((pme_sts & $past(pme_sts)) == $past(pme_sts)));
   assert_smi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_smi |=> ((smi_sts & $past(smi_sts)) == $past(smi_sts)));
   assert_agg_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_agg |=> ((agg_sts & $past(agg_sts)) == $past(agg_sts)));

   // R8: a bit being set in the same cycle as a clear ends up one.
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pme_sts & $past(irq_set)) == $past(irq_set)));

   generate
      if (!REG_OUT) begin : g_out_chk
         // R9: an interrupt request needs a latched status behind it.
         assert_pme_needs_sts_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pme_o |-> (pme_sts != '0));
         assert_smi_needs_sts_R9: assert property (@(posedge clk) disable iff (!rst_n)
            smi_o |-> (smi_sts != '0));
      end
   endgenerate
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS), .AW(AW), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
   .mode_q(mode_q), .any_edge(any_edge), .irq_set(irq_set),
   .pme_sts(pme_sts), .smi_sts(smi_sts), .agg_sts(agg_sts),
   .pme_o(pme_o), .smi_o(smi_o)
);

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
   localparam int N  = 6;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [N-1:0]  wdata = '0;
   logic [N-1:0]  rdata;
   logic          pme_o, smi_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   gpio_edge_irq #(.NPINS(N), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .pme_o(pme_o), .smi_o(smi_o)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [N-1:0] d);
      addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [N-1:0] d);
      addr = AW'(a);
      #1 d = rdata;
   endtask

   // Change pin levels and wait until the status has latched.
   task automatic drive(input logic [N-1:0] v);
      pin_in = v;
      step(3);
   endtask

   task automatic clear_all();
      wr(3, '1); wr(4, '1); wr(5, '1);
   endtask

   task automatic t_reset();
      logic [N-1:0] d;
      for (int a = 0; a < 7; a++) begin
         rd(a, d);
         chk($sformatf("R1 reg %0d after reset", a), d, '0);
      end
      chk("R1 pme_o after reset", N'(pme_o), '0);
      chk("R1 smi_o after reset", N'(smi_o), '0);
   endtask

   task automatic t_regmap();
      logic [N-1:0] d;
      wr(0, 6'h15); wr(1, 6'h2a); wr(2, 6'h33); wr(6, 6'h0c);
      rd(0, d); chk("R2 mode readback", d, 6'h15);
      rd(1, d); chk("R2 pme enable readback", d, 6'h2a);
      rd(2, d); chk("R2 smi enable readback", d, 6'h33);
      rd(6, d); chk("R2 polarity readback", d, 6'h0c);
      wr(0, '0); wr(1, '0); wr(2, '0); wr(6, '0);
   endtask

   task automatic t_either_edge();
      logic [N-1:0] d;
      clear_all();
      wr(0, 6'h01);
      drive(6'h01);
      rd(3, d); chk("R3 rise sets pme status", d, 6'h01);
      rd(4, d); chk("R3 rise sets smi status", d, 6'h01);
      clear_all();
      drive(6'h00);
      rd(3, d); chk("R3 fall sets pme status", d, 6'h01);
      rd(4, d); chk("R3 fall sets smi status", d, 6'h01);
      wr(0, '0); clear_all();
   endtask

   task automatic t_single_edge();
      logic [N-1:0] d;
      clear_all();
      wr(6, 6'h00);
      drive(6'h02);
      rd(3, d); chk("R4 pol0 rise sets", d, 6'h02);
      clear_all();
      drive(6'h00);
      rd(3, d); chk("R4 pol0 fall ignored", d, 6'h00);
      wr(6, 6'h02);
      drive(6'h02);
      rd(4, d); chk("R4 pol1 rise ignored", d, 6'h00);
      drive(6'h00);
      rd(4, d); chk("R4 pol1 fall sets", d, 6'h02);
      wr(6, '0); clear_all();
   endtask

   task automatic t_polarity_both();
      logic [N-1:0] d;
      clear_all();
      wr(0, 6'h04); wr(6, 6'h04);
      drive(6'h04);
      rd(3, d); chk("R5 pol1 either-edge rise sets", d, 6'h04);
      clear_all();
      drive(6'h00);
      rd(3, d); chk("R5 pol1 either-edge fall sets", d, 6'h04);
      wr(0, '0); wr(6, '0); clear_all();
   endtask

   task automatic t_aggregate();
      logic [N-1:0] d;
      clear_all();
      drive(6'h08);
      rd(5, d); chk("R6 aggregate rise mode off", d, 6'h08);
      clear_all();
      drive(6'h00);
      rd(5, d); chk("R6 aggregate fall mode off", d, 6'h08);
      clear_all();
   endtask

   task automatic t_w1c();
      logic [N-1:0] d;
      clear_all();
      drive(6'h30);  // rising edges on pins 4,5, mode off, polarity 0
      rd(3, d); chk("R7 setup pme", d, 6'h30);
      wr(3, 6'h10);
      rd(3, d); chk("R7 one clears, zero keeps (pme)", d, 6'h20);
      wr(4, 6'h00);
      rd(4, d); chk("R7 zero write keeps smi", d, 6'h30);
      wr(5, 6'h20);
      rd(5, d); chk("R7 one clears aggregate", d, 6'h10);
      drive(6'h00); clear_all();
   endtask

   task automatic t_collision();
      logic [N-1:0] d;
      clear_all();
      wr(0, 6'h01);
      pin_in = 6'h01;
      step(2);
      addr = AW'(3); wdata = 6'h01; wr_en = 1'b1;  // in force on 3rd edge
      step(1);
      wr_en = 1'b0;
      rd(3, d); chk("R8 set wins over clear", d, 6'h01);
      wr(3, 6'h01);
      rd(3, d); chk("R8 later clear works", d, 6'h00);
      drive(6'h00); wr(0, '0); clear_all();
   endtask

   task automatic t_irq_out();
      logic [N-1:0] d;
      clear_all();
      wr(0, 6'h10);
      drive(6'h10);
      rd(3, d); chk("R9 status latches with enable clear", d, 6'h10);
      chk("R9 pme_o low while disabled", N'(pme_o), '0);
      wr(1, 6'h10);
      chk("R9 pme_o rises on enable", N'(pme_o), 6'h01);
      chk("R9 smi_o low, smi enable clear", N'(smi_o), '0);
      wr(2, 6'h10);
      chk("R9 smi_o rises on enable", N'(smi_o), 6'h01);
      wr(0, 6'h00);
      chk("R9 pme_o low with mode off", N'(pme_o), '0);
      wr(0, 6'h10);
      step(2);
      chk("R9 pme_o held until cleared", N'(pme_o), 6'h01);
      wr(3, 6'h10);
      chk("R9 pme_o drops after clear", N'(pme_o), '0);
      chk("R9 smi_o still high", N'(smi_o), 6'h01);
      wr(4, 6'h10);
      chk("R9 smi_o drops after clear", N'(smi_o), '0);
      drive(6'h00);
      wr(0, '0); wr(1, '0); wr(2, '0); clear_all();
   endtask

   task automatic t_data();
      logic [N-1:0] d;
      drive(6'h29);
      rd(7, d); chk("R10 data polarity 0", d, 6'h29);
      wr(6, 6'h0f);
      rd(7, d); chk("R10 data polarity mixed", d, 6'h29 ^ 6'h0f);
      wr(6, '0);
      drive(6'h00);
      rd(7, d); chk("R10 data all low", d, 6'h00);
      clear_all();
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_regmap();
      t_either_edge();
      t_single_edge();
      t_polarity_both();
      t_aggregate();
      t_w1c();
      t_collision();
      t_irq_out();
      t_data();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule